// File: doc/BRIEF.md
# Card Clock Phase Select Register

This block is the control and status word that configures the clock unit of a card interface. It holds three 3-bit fields: a sample phase, a drive phase and a clock divider value. It also holds a sticky wake-up flag that hardware raises and software clears. Software reads and writes the word through a plain register port. A tuning engine can step the sample phase forward one position per strobe, or place a chosen sample phase directly. In both cases the other fields stay as they are.

When the timing mode changes, a mode-update strobe loads the three fields from one of two preset words. The DDR preset is used when double-data-rate timing is selected, and the SDR preset is used otherwise. The block derives a command hold-register enable from the drive phase and drives the wake-up flag straight out as an interrupt line. All pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `clk_phase_ctl`

## Requirements
- R1: After reset the whole read word is zero, wake_irq_o is 0 and hold_en_o is 0.
- R2: The read word places the sample phase in bits [2:0], the drive phase in bits [18:16], the divider value in bits [26:24] and the wake flag in bit 11. A register write loads each field from the same bit positions of reg_wdata_i, so every field is masked to 3 bits. All other bits read as 0, and writing them has no effect.
- R3: An advance strobe raises the sample phase by one, modulo 8, so 7 wraps to 0. It leaves every other bit unchanged. sample_o shows the new value from the cycle after the strobe.
- R4: A sample-set strobe replaces bits [2:0] with smpl_val_i and keeps every other bit.
- R5: wake_set_i sets the wake flag. A register write with bit 11 = 1 clears it, and a write with bit 11 = 0 leaves it unchanged. wake_irq_o always equals the flag.
- R6: When wake_set_i and a clearing write occur in the same cycle, the flag ends up set.
- R7: hold_en_o is 1 exactly when the drive-phase field is non-zero. It follows the field combinationally.
- R8: A mode-update strobe loads the three fields from ddr_preset_i when ddr_mode_i = 1, and from sdr_preset_i otherwise, using the same bit positions as R2. The preset's bit 11 and its unused bits are ignored, and the wake flag is not affected.
- R9: For the three fields, the order of precedence is: register write, then mode update, then sample-set, then advance. Only the highest-ranking request present in a cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Current register word |
| adv_i | input | 1 | Advance sample phase by one |
| smpl_set_i | input | 1 | Load sample phase from smpl_val_i |
| smpl_val_i | input | 3 | Sample phase value for smpl_set_i |
| mode_upd_i | input | 1 | Load fields from the selected preset |
| ddr_mode_i | input | 1 | 1 selects the DDR preset on a mode update |
| sdr_preset_i | input | 32 | SDR preset word |
| ddr_preset_i | input | 32 | DDR preset word |
| wake_set_i | input | 1 | Hardware wake-up event |
| sample_o | output | 3 | Current sample phase |
| hold_en_o | output | 1 | Commands use the hold register |
| wake_irq_o | output | 1 | Wake-up interrupt level |

## Verification
Two collisions matter most. The first is a wake-up event arriving in the same cycle as a software write that clears the flag. The bench provokes it by driving wake_set_i together with a write that has bit 11 set, and it expects the flag to remain 1. The second is a register write arriving in the same cycle as a mode update, a sample-set and an advance. The bench raises all four strobes on one clock edge and expects exactly the written fields. It then removes the requests one at a time, from the highest rank downward, and checks that each next-ranked request wins.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned FIELD_W    = 3;
  localparam int unsigned NUM_FIELDS = 3;
  localparam int unsigned WAKE_BIT   = 11;

  localparam int unsigned IDX_SMP = 0;
  localparam int unsigned IDX_DRV = 1;
  localparam int unsigned IDX_DIV = 2;

  typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_vec_t;

  function automatic int unsigned field_lsb(input int unsigned idx);
    case (idx)
      IDX_SMP: field_lsb = 0;
      IDX_DRV: field_lsb = 16;
      default: field_lsb = 24;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] field_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      m[field_lsb(i) +: FIELD_W] = '1;
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] used_mask();
    logic [DATA_W-1:0] m;
    m = field_mask();
    m[WAKE_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cps_field.sv
module cps_field #(
  parameter int unsigned FW      = 3,
  parameter bit          STEP_EN = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [FW-1:0] wdata_i,
  input  logic          load_i,
  input  logic [FW-1:0] load_val_i,
  input  logic          set_i,
  input  logic [FW-1:0] set_val_i,
  input  logic          step_i,
  output logic [FW-1:0] q_o
);
  logic [FW-1:0] q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_i) begin
      q <= wdata_i;
    end else if (load_i) begin
      q <= load_val_i;
    end else if (STEP_EN && set_i) begin
      q <= set_val_i;
    end else if (STEP_EN && step_i) begin
      q <= q + FW'(1);
    end
  end

  assign q_o = q;

  AST_WR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o == $past(wdata_i)); // R9

  AST_LOAD_OVER_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_i) |=> q_o == $past(load_val_i)); // R9

  generate
    if (STEP_EN) begin : g_step_chk
      AST_SET_REPLACES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i && !wr_i && !load_i) |=> q_o == $past(set_val_i)); // R4

      AST_STEP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !set_i && !wr_i && !load_i) |=> q_o == $past(q_o) + FW'(1)); // R3
    end
  endgenerate
endmodule

// File: rtl/cps_wake_flag.sv
module cps_wake_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flag <= 1'b0;
    end else if (set_i) begin
      flag <= 1'b1;
    end else if (clr_i) begin
      flag <= 1'b0;
    end
  end

  assign flag_o = flag;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R6

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o)); // R5
endmodule

// File: rtl/cps_readback.sv
module cps_readback
  import cps_pkg::*;
(
  input  field_vec_t        fields_i,
  input  logic              wake_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      rdata_o[field_lsb(i) +: FIELD_W] = fields_i[i];
    end
    rdata_o[WAKE_BIT] = wake_i;
  end
endmodule

// File: rtl/clk_phase_ctl.sv
module clk_phase_ctl
  import cps_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                adv_i,
  input  logic                smpl_set_i,
  input  logic [FIELD_W-1:0]  smpl_val_i,
  input  logic                mode_upd_i,
  input  logic                ddr_mode_i,
  input  logic [DATA_W-1:0]   sdr_preset_i,
  input  logic [DATA_W-1:0]   ddr_preset_i,
  input  logic                wake_set_i,
  output logic [FIELD_W-1:0]  sample_o,
  output logic                hold_en_o,
  output logic                wake_irq_o
);
  localparam logic [DATA_W-1:0] USED  = used_mask();
  localparam logic [DATA_W-1:0] FMASK = field_mask();

  field_vec_t        fq;
  logic [DATA_W-1:0] preset_sel;
  logic              wake_q;
  logic              wake_clr;

  assign preset_sel = ddr_mode_i ? ddr_preset_i : sdr_preset_i;
  assign wake_clr   = reg_wr_i & reg_wdata_i[WAKE_BIT];

  logic unused_bits;
  assign unused_bits = ^{reg_wdata_i & ~USED, sdr_preset_i & ~FMASK,
                         ddr_preset_i & ~FMASK};

  generate
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      localparam int unsigned LSB = field_lsb(g);
      localparam bit IS_SMP = (g == IDX_SMP);
      logic              set_req;
      logic              step_req;
      logic [FIELD_W-1:0] set_val;
      if (IS_SMP) begin : g_smp
        assign set_req  = smpl_set_i;
        assign step_req = adv_i;
        assign set_val  = smpl_val_i;
      end else begin : g_plain
        assign set_req  = 1'b0;
        assign step_req = 1'b0;
        assign set_val  = '0;
      end
      cps_field #(
        .FW      (FIELD_W),
        .STEP_EN (IS_SMP)
      ) u_field (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (reg_wr_i),
        .wdata_i    (reg_wdata_i[LSB +: FIELD_W]),
        .load_i     (mode_upd_i),
        .load_val_i (preset_sel[LSB +: FIELD_W]),
        .set_i      (set_req),
        .set_val_i  (set_val),
        .step_i     (step_req),
        .q_o        (fq[g])
      );
    end
  endgenerate

  cps_wake_flag u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wake_set_i),
    .clr_i  (wake_clr),
    .flag_o (wake_q)
  );

  cps_readback u_rb (
    .fields_i (fq),
    .wake_i   (wake_q),
    .rdata_o  (reg_rdata_o)
  );

  assign sample_o   = fq[IDX_SMP];
  assign hold_en_o  = |fq[IDX_DRV];
  assign wake_irq_o = wake_q;

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~USED) == '0); // R2

  AST_HOLD_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_en_o == (reg_rdata_o[field_lsb(IDX_DRV) +: FIELD_W] != '0)); // R7

  AST_ADV_KEEPS_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !reg_wr_i && !mode_upd_i && !wake_set_i)
      |=> (reg_rdata_o & ~FMASK) == ($past(reg_rdata_o) & ~FMASK)
          && fq[IDX_DRV] == $past(fq[IDX_DRV]) && fq[IDX_DIV] == $past(fq[IDX_DIV])); // R3

  AST_MODE_KEEPS_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_upd_i && !reg_wr_i && !wake_set_i) |=> $stable(wake_irq_o)); // R8

  AST_IRQ_IS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o == reg_rdata_o[WAKE_BIT]); // R5
endmodule

// File: tb/clk_phase_ctl_tb.sv
`timescale 1ns/1ps
module clk_phase_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        adv = 1'b0;
  logic        smpl_set = 1'b0;
  logic [2:0]  smpl_val = '0;
  logic        mode_upd = 1'b0;
  logic        ddr_mode = 1'b0;
  logic [31:0] sdr_preset = '0;
  logic [31:0] ddr_preset = '0;
  logic        wake_set = 1'b0;
  logic [2:0]  sample;
  logic        hold_en;
  logic        wake_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_phase_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .adv_i(adv), .smpl_set_i(smpl_set),
    .smpl_val_i(smpl_val), .mode_upd_i(mode_upd), .ddr_mode_i(ddr_mode),
    .sdr_preset_i(sdr_preset), .ddr_preset_i(ddr_preset),
    .wake_set_i(wake_set), .sample_o(sample), .hold_en_o(hold_en),
    .wake_irq_o(wake_irq)
  );

  function automatic logic [31:0] word(input logic [2:0] s, input logic [2:0] d,
                                       input logic [2:0] v, input logic w);
    return (32'(v) << 24) | (32'(d) << 16) | (32'(w) << 11) | 32'(s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge with strobes already driven: crosses one posedge,
  // clears all strobes at the following negedge.
  task automatic step();
    @(negedge clk);
    reg_wr = 0; adv = 0; smpl_set = 0; mode_upd = 0; wake_set = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d; step();
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 irq", 32'(wake_irq), 32'h0);
    chk("R1 hold", 32'(hold_en), 32'h0);
  endtask

  task automatic t_write();
    wr(32'hFFFF_F7FF);
    chk("R2 masked write", reg_rdata, word(3'd7, 3'd7, 3'd7, 1'b0));
    wr(word(3'd2, 3'd5, 3'd3, 1'b0) | 32'h00E0_E0F8);
    chk("R2 fields", reg_rdata, word(3'd2, 3'd5, 3'd3, 1'b0));
    chk("R2 sample_o", 32'(sample), 32'd2);
  endtask

  task automatic t_advance();
    wr(word(3'd6, 3'd4, 3'd1, 1'b0));
    adv = 1; step();
    chk("R3 step", reg_rdata, word(3'd7, 3'd4, 3'd1, 1'b0));
    adv = 1; step();
    chk("R3 wrap", reg_rdata, word(3'd0, 3'd4, 3'd1, 1'b0));
    chk("R3 sample_o", 32'(sample), 32'd0);
    adv = 1; step();
    chk("R3 after wrap", 32'(sample), 32'd1);
  endtask

  task automatic t_sample_set();
    wr(word(3'd1, 3'd6, 3'd2, 1'b0));
    wake_set = 1; step();
    smpl_set = 1; smpl_val = 3'd5; step();
    chk("R4 set keeps rest", reg_rdata, word(3'd5, 3'd6, 3'd2, 1'b1));
  endtask

  task automatic t_wake();
    wr(word(3'd0, 3'd0, 3'd0, 1'b1));
    chk("R5 clear", 32'(wake_irq), 32'h0);
    wake_set = 1; step();
    chk("R5 set irq", 32'(wake_irq), 32'h1);
    wr(word(3'd3, 3'd0, 3'd0, 1'b0));
    chk("R5 write0 keeps", reg_rdata, word(3'd3, 3'd0, 3'd0, 1'b1));
    wr(word(3'd3, 3'd0, 3'd0, 1'b1));
    chk("R5 w1c", reg_rdata, word(3'd3, 3'd0, 3'd0, 1'b0));
  endtask

  task automatic t_collide();
    wake_set = 1; reg_wr = 1; reg_wdata = word(3'd0, 3'd0, 3'd0, 1'b1); step();
    chk("R6 set beats clear", 32'(wake_irq), 32'h1);
    wr(word(3'd0, 3'd0, 3'd0, 1'b1));
  endtask

  task automatic t_hold();
    wr(word(3'd7, 3'd0, 3'd7, 1'b0));
    chk("R7 drive zero", 32'(hold_en), 32'h0);
    wr(word(3'd0, 3'd1, 3'd0, 1'b0));
    chk("R7 drive one", 32'(hold_en), 32'h1);
    wr(word(3'd0, 3'd4, 3'd0, 1'b0));
    chk("R7 drive four", 32'(hold_en), 32'h1);
  endtask

  task automatic t_mode();
    sdr_preset = word(3'd1, 3'd2, 3'd3, 1'b1) | 32'h8000_0100;
    ddr_preset = word(3'd4, 3'd0, 3'd6, 1'b1);
    wr(word(3'd0, 3'd0, 3'd0, 1'b1));
    ddr_mode = 0; mode_upd = 1; step();
    chk("R8 sdr", reg_rdata, word(3'd1, 3'd2, 3'd3, 1'b0));
    ddr_mode = 1; mode_upd = 1; step();
    chk("R8 ddr", reg_rdata, word(3'd4, 3'd0, 3'd6, 1'b0));
    chk("R8 ddr hold", 32'(hold_en), 32'h0);
    ddr_mode = 0;
  endtask

  task automatic t_priority();
    wr(word(3'd2, 3'd2, 3'd2, 1'b0));
    reg_wr = 1; reg_wdata = word(3'd6, 3'd1, 3'd5, 1'b0);
    mode_upd = 1; smpl_set = 1; smpl_val = 3'd3; adv = 1; step();
    chk("R9 write wins", reg_rdata, word(3'd6, 3'd1, 3'd5, 1'b0));
    mode_upd = 1; smpl_set = 1; smpl_val = 3'd3; adv = 1; step();
    chk("R9 mode wins", reg_rdata, word(3'd1, 3'd2, 3'd3, 1'b0));
    smpl_set = 1; smpl_val = 3'd3; adv = 1; step();
    chk("R9 set over adv", reg_rdata, word(3'd3, 3'd2, 3'd3, 1'b0));
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_advance();
    t_sample_set();
    t_wake();
    t_collide();
    t_hold();
    t_mode();
    t_priority();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule